// File: doc/BRIEF.md
# I2C Byte-at-a-Time Master

This block is an I2C bus master with no data buffering. Software writes one command word, and the block performs exactly one bus operation. The operation is one of four kinds: a START (or repeated START) followed by an address byte, one transmitted byte, one received byte, or a STOP. When the operation is over, the block emits a single one-cycle interrupt pulse. Software then reads a status word. That word holds the last byte seen on the bus, the bus-ownership, direction and error flags, and whether the bus is idle.

The lines are open-drain. Each line output is an enable that pulls the wire low. Bit timing is a fixed number of clock cycles per quarter bit. Both line inputs pass through synchronizers. Each high phase of SCL is counted only once SCL actually reads high, so a slave that stretches the clock is honoured.

A bus-reset register can freeze the engine and drive SCL by hand for bus recovery. A monitor register returns the synchronized levels of both lines. All registers sit on a simple register port: a write is a one-cycle strobe, and read data is valid in the same cycle as the address.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, the status word (offset 0x04) reads 0x100: only bit 8, bus free, is set. The bus-reset register (0x10) reads 0x3. Neither line is driven and `irq` is low.
- R2: A command at offset 0x00 with bit 10 set, sent while the bus is free, produces a START: SDA falls while SCL is high. The byte in bits 7:0 then goes out MSB first, followed by a ninth clock on which SDA is released. Status then shows bit 14 (master) = 1, bit 13 (transmit) = inverse of byte bit 0, bit 11 = the sampled acknowledge, and bits 7:0 = the byte.
- R3: A command with bits 10 and 9 clear sends the byte on 8 clocks while the master owns the bus in transmit direction. The slave's level on the ninth clock is stored in status bit 11 (1 = no acknowledge).
- R4: In receive direction a byte command ignores bits 7:0 and releases SDA for 8 clocks, storing the bits in status 7:0. On the ninth clock the master pulls SDA low when command bit 8 is 0 and releases it when bit 8 is 1.
- R5: Each finished operation whose command had bit 11 set gives exactly one `irq` pulse, one cycle long.
- R6: An operation whose command had bit 11 clear gives no `irq` pulse.
- R7: A command with bit 9 set and bit 10 clear produces a STOP: SDA rises while SCL is high. Afterwards status bit 14 = 0, bit 12 (stop seen) = 1 and bit 8 = 1.
- R8: If SDA reads low on a transmitted bit for which the master released SDA, status bit 9 is set, bit 14 clears, and both lines are released at once. No STOP follows, and `irq` still pulses.
- R9: With bus-reset bit 1 = 0 the engine is held idle and commands are ignored. SDA is released, and SCL is pulled low when bit 0 = 0 and released when bit 0 = 1.
- R10: The monitor register (0x18) returns the synchronized SDA level in bit 1 and SCL in bit 0.
- R11: A START command while the master already owns the bus gives a repeated START: SDA is released while SCL is low, then SCL rises, then SDA falls with SCL high. No STOP is seen.
- R12: While a slave holds SCL low after the master releases it, no bit is sampled and the operation waits. It resumes correctly once SCL is let go.
- R13: A command written while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | One-cycle write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, same cycle as address |
| irq | output | 1 | One-cycle completion pulse |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The properties assume that the line inputs behave as a wired-AND of this master and other devices. They also assume that register writes arrive as single-cycle strobes held stable for that cycle, and that reset is asserted before the first command. The bench's slave model combines its own pull-downs with the master's enables in just that way. The model changes SDA only after an SCL falling edge, except in the arbitration scenario, where it releases SDA only once the checks are complete. Clock stretching is applied only while SCL is already low, so the master never sees a line pulled against a level it is itself driving.

// File: rtl/i2cbm_pkg.sv
package i2cbm_pkg;
   // register byte offsets
   localparam int unsigned OFS_CMD  = 'h00;
   localparam int unsigned OFS_STAT = 'h04;
   localparam int unsigned OFS_BRST = 'h10;
   localparam int unsigned OFS_LMON = 'h18;
   // command word bit positions
   localparam int unsigned C_IRQEN = 11;
   localparam int unsigned C_STA   = 10;
   localparam int unsigned C_STO   = 9;
   localparam int unsigned C_NACK  = 8;
   // status word bit positions
   localparam int unsigned S_MST = 14;
   localparam int unsigned S_TX  = 13;
   localparam int unsigned S_STP = 12;
   localparam int unsigned S_LRB = 11;
   localparam int unsigned S_LAB = 9;
   localparam int unsigned S_BBN = 8;

   typedef enum logic [1:0] {OP_BYTE, OP_START, OP_STOP} op_e;

   typedef enum logic [3:0] {
      E_IDLE, E_SETA, E_SETB, E_RPA, E_RPB, E_RPC,
      E_BLO, E_BRISE, E_BHI, E_BFALL, E_PA, E_PB, E_PC, E_PD
   } eng_st_e;

   typedef struct packed {
      logic mst;
      logic tx;
      logic stp;
      logic lrb;
      logic lab;
   } eng_flags_t;
endpackage

// File: rtl/i2cbm_sync.sv
module i2cbm_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2cbm_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], d[i]};
      end
      assign q[i] = chain[STAGES-1];
   end
endmodule

// File: rtl/i2cbm_engine.sv
module i2cbm_engine
   import i2cbm_pkg::*;
#(
   parameter int unsigned QTR_CYC = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hold,
   input  logic       go,
   input  op_e        op,
   input  logic [7:0] byte_in,
   input  logic       nack_in,
   input  logic       scl_s,
   input  logic       sda_s,
   output logic       busy,
   output logic       done,
   output logic       scl_lo,
   output logic       sda_lo,
   output eng_flags_t flags,
   output logic [7:0] rx_byte
);
   localparam int unsigned CNT_W = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
   localparam logic [CNT_W-1:0] QLAST = CNT_W'(QTR_CYC - 1);

   eng_st_e        st;
   logic [CNT_W-1:0] qcnt;
   logic [3:0]     idx;
   logic [7:0]     shreg;
   logic           nack_q, txph, drv_q, own, tx_q, stp, lrb, lab;
   logic           timed, qtick, drv_now;

   assign timed   = !(st inside {E_IDLE, E_RPB, E_BRISE, E_PB});
   assign qtick   = timed && (qcnt == QLAST);
   assign drv_now = (idx == 4'd8) ? ~nack_q : (txph & ~shreg[7]);
   assign busy    = (st != E_IDLE);
   assign rx_byte = shreg;
   assign flags.mst = own;
   assign flags.tx  = tx_q;
   assign flags.stp = stp;
   assign flags.lrb = lrb;
   assign flags.lab = lab;

   always_comb begin
      scl_lo = 1'b0;
      sda_lo = 1'b0;
      case (st)
         E_IDLE:          scl_lo = own;
         E_SETA:          sda_lo = 1'b1;
         E_SETB, E_PA:    begin scl_lo = 1'b1; sda_lo = 1'b1; end
         E_RPA:           scl_lo = 1'b1;
         E_BLO:           begin scl_lo = 1'b1; sda_lo = drv_now; end
         E_BRISE, E_BHI:  sda_lo = drv_q;
         E_BFALL:         begin scl_lo = 1'b1; sda_lo = drv_q; end
         E_PB, E_PC:      sda_lo = 1'b1;
         default:         ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= E_IDLE; qcnt <= '0; idx <= '0; shreg <= '0; nack_q <= 1'b1;
         txph <= 1'b0; drv_q <= 1'b0; own <= 1'b0; tx_q <= 1'b0;
         stp <= 1'b0; lrb <= 1'b0; lab <= 1'b0; done <= 1'b0;
      end else if (hold) begin
         st <= E_IDLE; qcnt <= '0; own <= 1'b0; done <= 1'b0;
      end else begin
         done <= 1'b0;
         qcnt <= (timed && !qtick) ? qcnt + 1'b1 : '0;
         if (st == E_BLO) drv_q <= drv_now;
         case (st)
            E_IDLE: if (go) begin
               idx <= '0;
               case (op)
                  OP_START: begin
                     shreg <= byte_in; nack_q <= 1'b1; txph <= 1'b1;
                     tx_q <= ~byte_in[0]; stp <= 1'b0; lab <= 1'b0;
                     own <= 1'b1;
                     st  <= own ? E_RPA : E_SETA;
                  end
                  OP_STOP: st <= E_PA;
                  default: begin
                     shreg <= byte_in; nack_q <= nack_in; txph <= tx_q;
                     st <= E_BLO;
                  end
               endcase
            end
            E_SETA:  if (qtick) st <= E_SETB;
            E_SETB:  if (qtick) st <= E_BLO;
            E_RPA:   if (qtick) st <= E_RPB;
            E_RPB:   if (scl_s) st <= E_RPC;
            E_RPC:   if (qtick) st <= E_SETA;
            E_BLO:   if (qtick) st <= E_BRISE;
            E_BRISE: if (scl_s) st <= E_BHI;
            E_BHI: if (qtick) begin
               if (idx == 4'd8) begin
                  lrb <= sda_s;
                  st  <= E_BFALL;
               end else if (txph && shreg[7] && !sda_s) begin
                  lab <= 1'b1; own <= 1'b0; done <= 1'b1; st <= E_IDLE;
               end else begin
                  shreg <= {shreg[6:0], sda_s};
                  st    <= E_BFALL;
               end
            end
            E_BFALL: if (qtick) begin
               if (idx == 4'd8) begin
                  done <= 1'b1; st <= E_IDLE;
               end else begin
                  idx <= idx + 4'd1; st <= E_BLO;
               end
            end
            E_PA: if (qtick) st <= E_PB;
            E_PB: if (scl_s) st <= E_PC;
            E_PC: if (qtick) st <= E_PD;
            E_PD: if (qtick) begin
               own <= 1'b0; stp <= 1'b1; done <= 1'b1; st <= E_IDLE;
            end
            default: st <= E_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
   import i2cbm_pkg::*;
#(
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned QTR_CYC     = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe,
   output logic              sda_oe
);
   if (DATA_W < 16) begin : g_bad_data
      $error("i2c_byte_master: DATA_W must be at least 16");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("i2c_byte_master: ADDR_W must reach offset 0x18");
   end
   if (QTR_CYC < 4) begin : g_bad_qtr
      $error("i2c_byte_master: QTR_CYC must exceed synchronizer latency");
   end

   logic       scl_s, sda_s;
   logic       run_q, scl_rel_q, irqen_q;
   logic       eng_busy, eng_done, scl_lo, sda_lo, accept;
   logic [7:0] rx_byte;
   eng_flags_t eng_flags;
   op_e        op_sel;
   logic       unused_wbits;

   assign unused_wbits = ^reg_wdata[DATA_W-1:12];

   i2cbm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({sda_i, scl_i}), .q({sda_s, scl_s})
   );

   assign accept = reg_wr && (reg_addr == ADDR_W'(OFS_CMD)) && run_q && !eng_busy;
   assign op_sel = reg_wdata[C_STA] ? OP_START :
                   reg_wdata[C_STO] ? OP_STOP  : OP_BYTE;

   i2cbm_engine #(.QTR_CYC(QTR_CYC)) u_eng (
      .clk(clk), .rst_n(rst_n), .hold(!run_q), .go(accept), .op(op_sel),
      .byte_in(reg_wdata[7:0]), .nack_in(reg_wdata[C_NACK]),
      .scl_s(scl_s), .sda_s(sda_s), .busy(eng_busy), .done(eng_done),
      .scl_lo(scl_lo), .sda_lo(sda_lo), .flags(eng_flags), .rx_byte(rx_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b1; scl_rel_q <= 1'b1; irqen_q <= 1'b0;
         irq <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
      end else begin
         if (reg_wr && (reg_addr == ADDR_W'(OFS_BRST))) begin
            run_q     <= reg_wdata[1];
            scl_rel_q <= reg_wdata[0];
         end
         if (accept) irqen_q <= reg_wdata[C_IRQEN];
         irq    <= eng_done && irqen_q;
         scl_oe <= run_q ? scl_lo : !scl_rel_q;
         sda_oe <= run_q && sda_lo;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(OFS_STAT): begin
            reg_rdata[S_MST] = eng_flags.mst;
            reg_rdata[S_TX]  = eng_flags.tx;
            reg_rdata[S_STP] = eng_flags.stp;
            reg_rdata[S_LRB] = eng_flags.lrb;
            reg_rdata[S_LAB] = eng_flags.lab;
            reg_rdata[S_BBN] = !eng_busy && !eng_flags.mst && scl_s && sda_s;
            reg_rdata[7:0]   = rx_byte;
         end
         ADDR_W'(OFS_BRST): reg_rdata[1:0] = {run_q, scl_rel_q};
         ADDR_W'(OFS_LMON): reg_rdata[1:0] = {sda_s, scl_s};
         default: ;
      endcase
   end
endmodule

// File: rtl/i2cbm_checker.sv
module i2cbm_checker (
   input logic clk,
   input logic rst_n,
   input logic irq,
   input logic scl_oe,
   input logic sda_oe,
   input logic run_q,
   input logic scl_rel_q,
   input logic irqen_q,
   input logic eng_busy,
   input logic own
);
   p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(irqen_q));

   p_hold_sda_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |=> !sda_oe);

   p_hold_scl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |=> (scl_oe == !$past(scl_rel_q)));

   p_free_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !eng_busy && !own) |=> (!scl_oe && !sda_oe));
endmodule

bind i2c_byte_master i2cbm_checker u_chk (
   .clk(clk), .rst_n(rst_n), .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe),
   .run_q(run_q), .scl_rel_q(scl_rel_q), .irqen_q(irqen_q),
   .eng_busy(eng_busy), .own(eng_flags.mst)
);

// File: tb/i2c_byte_master_bench.sv
`timescale 1ns/1ps
module i2c_byte_master_bench;
   localparam logic [31:0] IRQ = 32'h800, STA = 32'h400, STO = 32'h200, NCK = 32'h100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq, scl_oe, sda_oe;
   logic        scl_w, sda_w, sda_pull;
   logic        slv_scl_hold = 1'b0;
   logic        slv_en = 1'b1;
   logic [8:0]  slv_pat = '0;
   logic [8:0]  mon_sh = '0;
   int fall_cnt = 0, fall_base = 0, base = 0, kk, rise_cnt = 0;
   int start_cnt = 0, stop_cnt = 0, irq_cnt = 0;
   int n_chk = 0, n_fail = 0;

   always #10 clk = ~clk;

   assign kk       = fall_cnt - fall_base - base;
   assign sda_pull = slv_en && ((kk >= 0 && kk <= 8) ? slv_pat[8-kk] : 1'b0);
   assign scl_w    = ~scl_oe & ~slv_scl_hold;
   assign sda_w    = ~sda_oe & ~sda_pull;

   i2c_byte_master u_i2c_byte_master (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .scl_i(scl_w), .sda_i(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe)
   );

   always @(negedge scl_w) fall_cnt = fall_cnt + 1;
   always @(posedge scl_w) begin rise_cnt = rise_cnt + 1; mon_sh = {mon_sh[7:0], sda_w}; end
   always @(negedge sda_w) if (scl_w) start_cnt = start_cnt + 1;
   always @(posedge sda_w) if (scl_w) stop_cnt = stop_cnt + 1;
   always @(posedge clk) if (irq) irq_cnt = irq_cnt + 1;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic issue(input logic [31:0] cmd, input logic [8:0] pat, input int b);
      fall_base = fall_cnt; base = b; slv_pat = pat;
      wr(5'h00, cmd);
   endtask

   task automatic wait_irq(input string req);
      int n = 0;
      while (!irq && n < 4000) begin @(negedge clk); n++; end
      chk(req, "irq seen", {31'd0, irq}, 32'd1);
      @(negedge clk);
      chk("R5", "irq one cycle", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      repeat (5) @(negedge clk);
      rd(5'h04, d); chk("R1", "status", d, 32'h100);
      rd(5'h10, d); chk("R1", "bus-reset reg", d, 32'h3);
      rd(5'h18, d); chk("R10", "line monitor idle", d, 32'h3);
      chk("R1", "irq/scl_oe/sda_oe", {29'd0, irq, scl_oe, sda_oe}, 32'd0);
   endtask

   task automatic t_start_write();
      int s0 = start_cnt, i0 = irq_cnt;
      logic [31:0] d;
      issue(IRQ | STA | NCK | 32'hA0, 9'h001, 1);
      wait_irq("R2");
      chk("R2", "start count", start_cnt - s0, 1);
      chk("R2", "bits on bus", {23'd0, mon_sh}, {23'd0, 8'hA0, 1'b0});
      rd(5'h04, d); chk("R2", "status", d, 32'h60A0);
      chk("R5", "irq count", irq_cnt - i0, 1);
   endtask

   task automatic t_tx_nack();
      logic [31:0] d;
      issue(IRQ | NCK | 32'h3C, 9'h000, 0);
      wait_irq("R3");
      chk("R3", "bits on bus", {23'd0, mon_sh}, {23'd0, 8'h3C, 1'b1});
      rd(5'h04, d); chk("R3", "status nack", d, 32'h683C);
   endtask

   task automatic t_no_irq();
      int i0 = irq_cnt;
      logic [31:0] d;
      issue(NCK | 32'hC5, 9'h001, 0);
      repeat (800) @(negedge clk);
      chk("R6", "no irq", irq_cnt - i0, 0);
      chk("R3", "bits on bus", {23'd0, mon_sh}, {23'd0, 8'hC5, 1'b0});
      rd(5'h04, d); chk("R3", "status ack", d, 32'h60C5);
   endtask

   task automatic t_stretch();
      int r0, i0 = irq_cnt, n = 0;
      issue(IRQ | NCK | 32'h5A, 9'h001, 0);
      while ((fall_cnt - fall_base) < 3 && n < 2000) begin @(negedge clk); n++; end
      slv_scl_hold = 1'b1;
      r0 = rise_cnt;
      repeat (300) @(negedge clk);
      chk("R12", "no clock while held", rise_cnt - r0, 0);
      chk("R12", "no irq while held", irq_cnt - i0, 0);
      slv_scl_hold = 1'b0;
      wait_irq("R12");
      chk("R12", "bits after stretch", {23'd0, mon_sh}, {23'd0, 8'h5A, 1'b0});
   endtask

   task automatic t_busy_ignore();
      int p0 = stop_cnt, i0 = irq_cnt;
      issue(IRQ | STA | NCK | 32'h76, 9'h001, 1);
      repeat (20) @(negedge clk);
      wr(5'h00, IRQ | STO | NCK);
      wait_irq("R13");
      repeat (600) @(negedge clk);
      chk("R13", "no stop from ignored cmd", stop_cnt - p0, 0);
      chk("R13", "single irq", irq_cnt - i0, 1);
      chk("R13", "first op bits", {23'd0, mon_sh}, {23'd0, 8'h76, 1'b0});
   endtask

   task automatic t_restart_read();
      int s0 = start_cnt, p0 = stop_cnt;
      logic [31:0] d;
      issue(IRQ | STA | NCK | 32'hA1, 9'h001, 1);
      wait_irq("R11");
      chk("R11", "repeated start seen", start_cnt - s0, 1);
      chk("R11", "no stop", stop_cnt - p0, 0);
      rd(5'h04, d); chk("R11", "status read dir", d, 32'h40A1);
      issue(IRQ | 32'h00, {~8'h96, 1'b0}, 0);
      wait_irq("R4");
      chk("R4", "master ack", {23'd0, mon_sh}, {23'd0, 8'h96, 1'b0});
      rd(5'h04, d); chk("R4", "rx byte", d, 32'h4096);
      issue(IRQ | NCK | 32'hFF, {~8'h5A, 1'b0}, 0);
      wait_irq("R4");
      chk("R4", "master nack", {23'd0, mon_sh}, {23'd0, 8'h5A, 1'b1});
      rd(5'h04, d); chk("R4", "last rx byte", d, 32'h485A);
   endtask

   task automatic t_stop();
      int p0 = stop_cnt;
      logic [31:0] d;
      issue(IRQ | STO | NCK, 9'h000, 0);
      wait_irq("R7");
      chk("R7", "stop seen", stop_cnt - p0, 1);
      rd(5'h04, d); chk("R7", "status after stop", d & 32'h5100, 32'h1100);
   endtask

   task automatic t_bus_reset();
      int s0, i0;
      logic [31:0] d;
      wr(5'h10, 32'h0);
      repeat (10) @(negedge clk);
      chk("R9", "scl driven sda free", {30'd0, scl_oe, sda_oe}, 32'h2);
      rd(5'h18, d); chk("R10", "monitor scl low", d, 32'h2);
      wr(5'h10, 32'h1);
      repeat (10) @(negedge clk);
      rd(5'h18, d); chk("R9", "scl released in hold", d, 32'h3);
      s0 = start_cnt; i0 = irq_cnt;
      wr(5'h00, IRQ | STA | NCK | 32'hA0);
      repeat (400) @(negedge clk);
      chk("R9", "cmd ignored start", start_cnt - s0, 0);
      chk("R9", "cmd ignored irq", irq_cnt - i0, 0);
      wr(5'h10, 32'h3);
      rd(5'h10, d); chk("R9", "run restored", d, 32'h3);
   endtask

   task automatic t_arbitration();
      int p0 = stop_cnt, i0 = irq_cnt;
      logic [31:0] d;
      repeat (10) @(negedge clk);
      issue(IRQ | STA | NCK | 32'h80, 9'h100, 1);
      wait_irq("R8");
      rd(5'h04, d); chk("R8", "lost flag, not master", d & 32'h4200, 32'h0200);
      chk("R8", "lines released", {30'd0, scl_oe, sda_oe}, 32'd0);
      chk("R8", "no stop", stop_cnt - p0, 0);
      chk("R8", "irq pulsed", irq_cnt - i0, 1);
      slv_en = 1'b0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_start_write();
      t_tx_nack();
      t_no_irq();
      t_stretch();
      t_busy_ignore();
      t_restart_read();
      t_stop();
      t_bus_reset();
      t_arbitration();
      repeat (20) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule